// File: doc/BRIEF.md
# Dual Programmable Clock Postscaler

This block holds two independent clock postscalers. Each takes a fast source clock and divides it by a ratio chosen with a 3-bit code. The ratio steps are 1, 2, 3, 4, 6, 8 and 12, and the two highest codes both give 12. Divider A always runs from source clock A. Divider B runs from either source A or source B, as picked by a select input.

Each divider has its own synchronous reset. While that reset is held, the divider output is low and its ratio code has no visible effect. After release, the divider runs one full silent lap before the first output pulse appears. A new code is taken up only at the rising source edge that begins a period, so a ratio change never produces a runt pulse.

Top module: `clk_postscaler`

## Requirements
- R1: Codes 0, 1, 2 and 3 give output periods of 1, 2, 3 and 4 source cycles.
- R2: Code 4 gives a period of 6 source cycles, code 5 gives 8, and codes 6 and 7 both give 12.
- R3: At a ratio of 3, the output is high for one and a half source cycles of every three, starting at a rising source edge.
- R4: While a divider's reset is sampled high at a rising source edge, its output is low from that edge on, and changes to its code have no effect on the output.
- R5: Count the first rising source edge that samples the reset low as edge 1. The first output rise then occurs at edge N, where N is the ratio decoded from the code present at the last rising edge that sampled the reset high.
- R6: The code present at the rising source edge that begins a period sets the ratio for that whole period. A code change at any other time is applied only at the next period boundary.
- R7: The two dividers are independent. Resetting or re-coding one leaves the other's output sequence unchanged.
- R8: With select low, divider B runs from source A; with select high, it runs from source B. The select is changed only while divider B's reset is held.
- R9: For every ratio N, the output is high for exactly the first N source half-cycles of each period. For N = 1, this means the output follows the source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_a | input | 1 | Source clock A, which feeds divider A and optionally divider B |
| ref_clk_b | input | 1 | Source clock B, an alternative source for divider B |
| b_src_sel | input | 1 | Selects divider B's source: 0 picks clock A, 1 picks clock B |
| a_div_rst | input | 1 | Synchronous reset for divider A, active high |
| a_ratio | input | 3 | Ratio code for divider A |
| b_div_rst | input | 1 | Synchronous reset for divider B, active high |
| b_ratio | input | 3 | Ratio code for divider B |
| a_clk_out | output | 1 | Divided clock from divider A |
| b_clk_out | output | 1 | Divided clock from divider B |

## Verification
The hardest cases to reach involve timing inside a period. One is a reset that lands while a divide-by-3 output is in its half-cycle tail, which is held up by the falling-edge stage. Another is a code change that arrives in the middle of a period rather than at its boundary. The stimulus changes codes and resets on falling source edges at cycle counts that do not line up with the running ratio, so both cases occur. A behavioural half-cycle model compares both outputs after every source edge, with divider B checked on each of its two sources.

// File: rtl/clk_postscaler.sv
module clk_postscaler #(
  parameter int RATIO_W = 3,
  parameter int CNT_W   = 4
) (
  input  logic               ref_clk_a,
  input  logic               ref_clk_b,
  input  logic               b_src_sel,
  input  logic               a_div_rst,
  input  logic [RATIO_W-1:0] a_ratio,
  input  logic               b_div_rst,
  input  logic [RATIO_W-1:0] b_ratio,
  output logic               a_clk_out,
  output logic               b_clk_out
);
  localparam int NDIV = 2;
  localparam logic [CNT_W-1:0] THREE = CNT_W'(3);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [NDIV-1:0]    src, drst, dout;
  logic [RATIO_W-1:0] code [NDIV];

  assign src[0]  = ref_clk_a;
  assign src[1]  = b_src_sel ? ref_clk_b : ref_clk_a;
  assign drst    = {b_div_rst, a_div_rst};
  assign code[0] = a_ratio;
  assign code[1] = b_ratio;
  assign a_clk_out = dout[0];
  assign b_clk_out = dout[1];

  function automatic logic [CNT_W-1:0] ratio_of(input logic [RATIO_W-1:0] c);
    case (c)
      RATIO_W'(0): ratio_of = CNT_W'(1);
      RATIO_W'(1): ratio_of = CNT_W'(2);
      RATIO_W'(2): ratio_of = CNT_W'(3);
      RATIO_W'(3): ratio_of = CNT_W'(4);
      RATIO_W'(4): ratio_of = CNT_W'(6);
      RATIO_W'(5): ratio_of = CNT_W'(8);
      default:     ratio_of = CNT_W'(12);
    endcase
  endfunction

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    logic [CNT_W-1:0] cnt, div;
    logic first, hi, neg;
    logic wrap;

    assign wrap = (cnt == div - ONE);

    always_ff @(posedge src[g]) begin
      if (drst[g]) begin
        cnt   <= '0;
        div   <= ratio_of(code[g]);
        first <= 1'b1;
        hi    <= 1'b0;
      end else if (wrap) begin
        cnt   <= '0;
        div   <= ratio_of(code[g]);
        first <= 1'b0;
        hi    <= 1'b1;
      end else begin
        cnt <= cnt + ONE;
        hi  <= !first && ((cnt + ONE) < (div >> 1));
      end
    end

    always_ff @(negedge src[g])
      neg <= hi && (div == THREE);

    assign dout[g] = (div == ONE) ? (src[g] & hi) : (hi | (neg & !first));

    assert_cnt_in_range_R1: assert property (@(posedge src[g]) disable iff (drst[g])
      cnt < div);

    assert_ratio_held_R6: assert property (@(posedge src[g]) disable iff (drst[g])
      !wrap |=> $stable(div));

    assert_silent_lead_R5: assert property (@(posedge src[g]) disable iff (drst[g])
      first |-> !hi);

    assert_period_starts_high_R9: assert property (@(posedge src[g]) disable iff (drst[g])
      wrap |=> hi);
  end
endmodule

// File: tb/tb_clk_postscaler.sv
module tb_clk_postscaler;
  logic ref_clk_a = 1'b0, ref_clk_b = 1'b0;
  logic b_src_sel = 1'b0;
  logic rst_d [2];
  logic [2:0] ratio_d [2];
  logic a_clk_out, b_clk_out;
  string tag [2];
  int n_cmp = 0, n_bad = 0;

  always #5 ref_clk_a = ~ref_clk_a;
  always #7 ref_clk_b = ~ref_clk_b;

  clk_postscaler dut (
    .ref_clk_a(ref_clk_a), .ref_clk_b(ref_clk_b), .b_src_sel(b_src_sel),
    .a_div_rst(rst_d[0]), .a_ratio(ratio_d[0]),
    .b_div_rst(rst_d[1]), .b_ratio(ratio_d[1]),
    .a_clk_out(a_clk_out), .b_clk_out(b_clk_out)
  );

  function automatic int ratio_ref(input logic [2:0] c);
    if (c < 3'd4) return int'(c) + 1;
    if (c == 3'd4) return 6;
    if (c == 3'd5) return 8;
    return 12;
  endfunction

  task automatic compare(input int d, input logic expv);
    logic act;
    act = (d == 0) ? a_clk_out : b_clk_out;
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s div%0d t=%0t actual=%b expected=%b", tag[d], d, $time, act, expv);
    end
  endtask

  // Half-cycle model: mode 0 held, 1 silent lead lap, 2 running
  task automatic model(input int d);
    int mode = 0, c = 0, h = 0, n = 1, nlead = 1;
    forever begin
      if (d == 1 && b_src_sel) @(posedge ref_clk_b); else @(posedge ref_clk_a);
      if (rst_d[d]) begin
        mode = 0;
        nlead = ratio_ref(ratio_d[d]);
      end else if (mode == 0 || mode == 1) begin
        c = (mode == 0) ? 1 : c + 1;
        mode = 1;
        if (c == nlead) begin mode = 2; h = 0; n = ratio_ref(ratio_d[d]); end
      end else begin
        h++;
        if (h == 2 * n) begin h = 0; n = ratio_ref(ratio_d[d]); end
      end
      #1 compare(d, mode == 2 && h < n);
      if (d == 1 && b_src_sel) @(negedge ref_clk_b); else @(negedge ref_clk_a);
      if (mode == 2) h++;
      #1 compare(d, mode == 2 && h < n);
    end
  endtask

  initial model(0);
  initial model(1);

  task automatic wait_a(input int k);
    repeat (k) @(negedge ref_clk_a);
  endtask

  task automatic wait_b(input int k);
    repeat (k) begin
      if (b_src_sel) @(negedge ref_clk_b); else @(negedge ref_clk_a);
    end
  endtask

  task automatic run_a;
    tag[0] = "R4"; rst_d[0] = 1'b1; ratio_d[0] = 3'd5;
    wait_a(3); ratio_d[0] = 3'd2; wait_a(2); ratio_d[0] = 3'd7; wait_a(2);
    ratio_d[0] = 3'd3; wait_a(2);
    tag[0] = "R5"; rst_d[0] = 1'b0; wait_a(30);
    for (int c = 0; c < 8; c++) begin
      rst_d[0] = 1'b1; ratio_d[0] = 3'(c); wait_a(2);
      tag[0] = (c == 2) ? "R3" : (c < 4) ? "R1" : "R2";
      rst_d[0] = 1'b0; wait_a(5 * ratio_ref(3'(c)) + 3);
    end
    tag[0] = "R6"; ratio_d[0] = 3'd5; wait_a(13);
    ratio_d[0] = 3'd0; wait_a(11);
    ratio_d[0] = 3'd2; wait_a(7);
    ratio_d[0] = 3'd4; wait_a(1);
    ratio_d[0] = 3'd1; wait_a(17);
    tag[0] = "R9"; ratio_d[0] = 3'd6; wait_a(40);
    tag[0] = "R4"; ratio_d[0] = 3'd2; wait_a(10);
    rst_d[0] = 1'b1; wait_a(1); ratio_d[0] = 3'd0; wait_a(4);
    tag[0] = "R7"; ratio_d[0] = 3'd1; rst_d[0] = 1'b0; wait_a(150);
  endtask

  task automatic run_b;
    tag[1] = "R4"; rst_d[1] = 1'b1; ratio_d[1] = 3'd1;
    wait_b(40);
    tag[1] = "R7"; ratio_d[1] = 3'd3; wait_b(1); rst_d[1] = 1'b0; wait_b(30);
    rst_d[1] = 1'b1; ratio_d[1] = 3'd2; wait_b(3); rst_d[1] = 1'b0; wait_b(20);
    for (int s = 0; s < 2; s++) begin
      rst_d[1] = 1'b1; wait_b(3);
      b_src_sel = 1'(s); wait_b(4);
      for (int c = 0; c < 8; c++) begin
        rst_d[1] = 1'b1; ratio_d[1] = 3'(7 - c); wait_b(2);
        tag[1] = "R8"; rst_d[1] = 1'b0; wait_b(4 * ratio_ref(3'(7 - c)) + 5);
      end
      tag[1] = "R6"; ratio_d[1] = 3'd2; wait_b(9); ratio_d[1] = 3'd5; wait_b(5);
      ratio_d[1] = 3'd0; wait_b(19);
    end
  endtask

  initial begin
    rst_d[0] = 1'b1; rst_d[1] = 1'b1; ratio_d[0] = 3'd0; ratio_d[1] = 3'd0;
    tag[0] = "R4"; tag[1] = "R4";
    fork
      run_a;
      run_b;
    join
    wait_a(4);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired t=%0t actual=running expected=done", $time);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule